// File: doc/BRIEF.md
# Host Cycle and Command Sequencer for an Associative Memory

This block is the host-facing front end of a 64-bit associative memory reached over a shared 32-bit bus that carries both data and commands. On every clock where the access enable is high, two select inputs classify the transfer as a command write, data write, command read or data read. Command writes carry an opcode in the upper byte. They load configuration registers, pick the destination for data transfers, switch between two configuration banks, load the address register, set up register reads or start a compare.

Data transfers are 32 bits wide and are paired into 64-bit words by a one-bit segment counter, with the low half first. A completed word goes to the comparand, to either mask, or to the memory array through a write request. Loading the comparand, a mask or the control register raises a compare request to the array logic, which lies outside this block. A register read takes two accesses: a command write sets it up, and the next access must be a command read. Any other type of access cancels it. A plain command read returns a 32-bit status word built from the array's compare result and the sequencer's own state.

Top module: `cam_host_seq`

## Requirements
- R1: `dq_oe` is 1 exactly when `acc_en`=1 and `acc_wr`=0. `dq_out` is zero for idle cycles and write accesses. Access types are: `acc_wr`=1,`acc_cmd`=1 command write; `acc_wr`=1,`acc_cmd`=0 data write; `acc_wr`=0,`acc_cmd`=1 command read; `acc_wr`=0,`acc_cmd`=0 data read.
- R2: A command read with no register read pending returns status {res_hit, res_multi, active bank, segment count, 12'b0, res_addr[15:0]} in the same cycle.
- R3: A command write with opcode 8'h10 in bits 31:24 and bit 16 = 1 writes bits 15:0 to the register chosen by bits 18:17 (0 control, 1 segment control, 2 address, 3 page). The address register takes bits AW-1:0.
- R4: Opcode 8'h10 with bit 16 = 0 sets up a read of the register chosen by bits 18:17. If the next access is a command read, it returns {status[31:16], value}, or {16'h0, value} for the page register. The value is zero-extended to 16 bits. Any other type of next access cancels the read.
- R5: Opcode 8'h20 sets the active bank's data destination from bits 17:16 (0 comparand, 1 mask 1, 2 mask 2, 3 memory). The second data write of a pair completes the word {second, first} and stores it at that destination.
- R6: `cmp_req` pulses for one cycle, starting the cycle after one of these: a completed comparand or mask word, a control register write, or opcode 8'h40. It never pulses after any other access, including unknown opcodes.
- R7: The segment counter toggles on every data access. It clears on a segment control write and on a bank switch. A data read returns the low half of the destination register when the count is 0 and the high half when it is 1. It returns zero when the destination is memory.
- R8: Opcode 8'h30 makes bit 16 the active bank. Control, segment control, address, mask 1 and destination exist once per bank. Comparand, mask 2 and page are shared.
- R9: When a completed word goes to memory, `mem_we` pulses in the next cycle with `mem_addr` equal to the address register and `mem_wdata` equal to the word. The address then steps by +1 if control[1:0]=01 or by −1 if control[1:0]=10, modulo 2^AW.
- R10: Opcode 8'h50 loads the active bank's address register from bits AW-1:0.
- R11: `cmp_mask` equals mask 1 of the active bank when control[3:2]=01, mask 2 when it is 10, and all ones otherwise. `cmp_key` equals the comparand.
- R12: After reset, all registers are zero, bank 0 is active and no request is raised. Idle cycles change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | An access takes place this cycle |
| acc_wr | input | 1 | 1 = write access, 0 = read access |
| acc_cmd | input | 1 | 1 = command access, 0 = data access |
| dq_in | input | 32 | Bus value driven by the host |
| dq_out | output | 32 | Bus value returned on reads |
| dq_oe | output | 1 | Bus output enable |
| res_hit | input | 1 | Array compare found a match |
| res_multi | input | 1 | Array compare found several matches |
| res_addr | input | 16 | Address of the highest-priority match |
| cmp_req | output | 1 | Compare request pulse |
| cmp_key | output | 64 | Comparand |
| cmp_mask | output | 64 | Compare mask in force |
| mem_we | output | 1 | Array write request pulse |
| mem_addr | output | AW | Array write address |
| mem_wdata | output | 64 | Array write word |

## Verification
The bench builds the block with AW=4, so the address register wraps after only sixteen locations. A few memory words in increment mode, and then in decrement mode, cross the wrap point in both directions. The bench also switches banks while each bank holds different control and mask values, so the per-bank storage shows up in `cmp_mask` and in readback. It interleaves register-read setup commands with matching and cancelling follow-up accesses, and it clears the segment counter in the middle of a word.

// File: rtl/cam_host_seq.sv
module cam_host_seq #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_en,
  input  logic          acc_wr,
  input  logic          acc_cmd,
  input  logic [31:0]   dq_in,
  output logic [31:0]   dq_out,
  output logic          dq_oe,
  input  logic          res_hit,
  input  logic          res_multi,
  input  logic [15:0]   res_addr,
  output logic          cmp_req,
  output logic [63:0]   cmp_key,
  output logic [63:0]   cmp_mask,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [63:0]   mem_wdata
);
  localparam logic [7:0] OP_REG  = 8'h10;
  localparam logic [7:0] OP_DST  = 8'h20;
  localparam logic [7:0] OP_BANK = 8'h30;
  localparam logic [7:0] OP_CMP  = 8'h40;
  localparam logic [7:0] OP_ADDR = 8'h50;

  logic          bank, seg_cnt, rd_pend;
  logic [1:0]    rd_idx;
  logic [31:0]   lo_hold;
  logic [15:0]   ctrl_q [2];
  logic [15:0]   segc_q [2];
  logic [AW-1:0] addr_q [2];
  logic [63:0]   mask1_q [2];
  logic [1:0]    dst_q [2];
  logic [63:0]   cmpd_q, mask2_q;
  logic [15:0]   page_q;

  wire cw = acc_en &  acc_wr &  acc_cmd;
  wire dw = acc_en &  acc_wr & ~acc_cmd;
  wire cr = acc_en & ~acc_wr &  acc_cmd;
  wire dr = acc_en & ~acc_wr & ~acc_cmd;
  wire [7:0]  op     = dq_in[31:24];
  wire        is_reg = cw && (op == OP_REG);
  wire        reg_rd = is_reg & ~dq_in[16];
  wire [1:0]  ridx   = dq_in[18:17];
  wire        wdone  = dw & seg_cnt;
  wire [63:0] word   = {dq_in, lo_hold};

  wire [31:0] status = {res_hit, res_multi, bank, seg_cnt, 12'h000, res_addr};

  logic [15:0] addr16, regval;
  logic [63:0] dsel;

  always_comb begin
    addr16 = '0;
    addr16[AW-1:0] = addr_q[bank];
    case (rd_idx)
      2'd0:    regval = ctrl_q[bank];
      2'd1:    regval = segc_q[bank];
      2'd2:    regval = addr16;
      default: regval = page_q;
    endcase
    case (dst_q[bank])
      2'd0:    dsel = cmpd_q;
      2'd1:    dsel = mask1_q[bank];
      2'd2:    dsel = mask2_q;
      default: dsel = '0;
    endcase
  end

  always_comb begin
    dq_out = '0;
    if (cr) begin
      if (rd_pend) dq_out = {(rd_idx == 2'd3) ? 16'h0000 : status[31:16], regval};
      else         dq_out = status;
    end else if (dr) begin
      dq_out = seg_cnt ? dsel[63:32] : dsel[31:0];
    end
  end

  assign dq_oe   = acc_en & ~acc_wr;
  assign cmp_key = cmpd_q;
  assign cmp_mask = (ctrl_q[bank][3:2] == 2'b01) ? mask1_q[bank] :
                    (ctrl_q[bank][3:2] == 2'b10) ? mask2_q : {64{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank <= 1'b0; seg_cnt <= 1'b0; rd_pend <= 1'b0; rd_idx <= '0;
      lo_hold <= '0; cmpd_q <= '0; mask2_q <= '0; page_q <= '0;
      cmp_req <= 1'b0; mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
      for (int i = 0; i < 2; i++) begin
        ctrl_q[i] <= '0; segc_q[i] <= '0; addr_q[i] <= '0;
        mask1_q[i] <= '0; dst_q[i] <= '0;
      end
    end else begin
      cmp_req <= 1'b0;
      mem_we  <= 1'b0;
      if (acc_en) rd_pend <= reg_rd;
      if (reg_rd) rd_idx <= ridx;
      if (dw | dr) seg_cnt <= ~seg_cnt;
      if (dw & ~seg_cnt) lo_hold <= dq_in;
      if (wdone) begin
        case (dst_q[bank])
          2'd0: begin cmpd_q <= word; cmp_req <= 1'b1; end
          2'd1: begin mask1_q[bank] <= word; cmp_req <= 1'b1; end
          2'd2: begin mask2_q <= word; cmp_req <= 1'b1; end
          default: begin
            mem_we    <= 1'b1;
            mem_addr  <= addr_q[bank];
            mem_wdata <= word;
            if (ctrl_q[bank][1:0] == 2'b01)      addr_q[bank] <= addr_q[bank] + AW'(1);
            else if (ctrl_q[bank][1:0] == 2'b10) addr_q[bank] <= addr_q[bank] - AW'(1);
          end
        endcase
      end
      if (cw) begin
        case (op)
          OP_REG: if (dq_in[16]) begin
            case (ridx)
              2'd0: begin ctrl_q[bank] <= dq_in[15:0]; cmp_req <= 1'b1; end
              2'd1: begin segc_q[bank] <= dq_in[15:0]; seg_cnt <= 1'b0; end
              2'd2: addr_q[bank] <= dq_in[AW-1:0];
              default: page_q <= dq_in[15:0];
            endcase
          end
          OP_DST:  dst_q[bank] <= dq_in[17:16];
          OP_BANK: begin bank <= dq_in[16]; seg_cnt <= 1'b0; end
          OP_CMP:  cmp_req <= 1'b1;
          OP_ADDR: addr_q[bank] <= dq_in[AW-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cam_host_seq_chk.sv
module cam_host_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic acc_en,
  input logic acc_wr,
  input logic acc_cmd,
  input logic cmp_req,
  input logic mem_we,
  input logic seg_cnt,
  input logic bank,
  input logic rd_pend
);
  assert_req_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_req |-> $past(acc_en && acc_wr));

  assert_memwe_after_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(acc_en && acc_wr && !acc_cmd));

  assert_single_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmp_req && mem_we));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> ($stable(seg_cnt) && $stable(bank) && $stable(rd_pend)));

  assert_pend_cancel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !(acc_wr && acc_cmd)) |=> !rd_pend);
endmodule

bind cam_host_seq cam_host_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_cmd(acc_cmd),
  .cmp_req(cmp_req), .mem_we(mem_we), .seg_cnt(seg_cnt), .bank(bank), .rd_pend(rd_pend)
);

// File: tb/tb_cam_host_seq.sv
module tb_cam_host_seq;
  localparam int AW = 4;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, acc_en, acc_wr, acc_cmd, res_hit, res_multi;
  logic [31:0] dq_in;
  logic [15:0] res_addr;
  wire  [31:0] dq_out;
  wire         dq_oe, cmp_req, mem_we;
  wire  [63:0] cmp_key, cmp_mask, mem_wdata;
  wire  [AW-1:0] mem_addr;

  cam_host_seq #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_cmd(acc_cmd),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .res_hit(res_hit),
    .res_multi(res_multi), .res_addr(res_addr), .cmp_req(cmp_req), .cmp_key(cmp_key),
    .cmp_mask(cmp_mask), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  int total = 0, bad = 0;
  bit done = 0;

  logic m_bank, m_seg, m_pend, m_req, m_we;
  logic [1:0] m_idx;
  logic [31:0] m_lo;
  logic [15:0] m_ctrl [2];
  logic [15:0] m_segc [2];
  int          m_addr [2];
  logic [63:0] m_mask1 [2];
  logic [1:0]  m_dst [2];
  logic [63:0] m_cmpd, m_mask2, m_mwd;
  logic [15:0] m_page;
  int          m_maddr;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_status();
    return {res_hit, res_multi, m_bank, m_seg, 12'h000, res_addr};
  endfunction

  function automatic logic [15:0] m_regval(logic [1:0] i);
    case (i)
      2'd0: return m_ctrl[m_bank];
      2'd1: return m_segc[m_bank];
      2'd2: return 16'(m_addr[m_bank]);
      default: return m_page;
    endcase
  endfunction

  function automatic logic [31:0] exp_dq();
    logic [31:0] st;
    logic [63:0] w;
    st = m_status();
    if (acc_en && !acc_wr && acc_cmd) begin
      if (m_pend) return {(m_idx == 2'd3) ? 16'h0 : st[31:16], m_regval(m_idx)};
      return st;
    end
    if (acc_en && !acc_wr && !acc_cmd) begin
      case (m_dst[m_bank])
        2'd0: w = m_cmpd;
        2'd1: w = m_mask1[m_bank];
        2'd2: w = m_mask2;
        default: w = 64'h0;
      endcase
      return m_seg ? w[63:32] : w[31:0];
    end
    return 32'h0;
  endfunction

  function automatic logic [63:0] exp_mask();
    case (m_ctrl[m_bank][3:2])
      2'b01: return m_mask1[m_bank];
      2'b10: return m_mask2;
      default: return {64{1'b1}};
    endcase
  endfunction

  task automatic m_reset();
    m_bank = 0; m_seg = 0; m_pend = 0; m_req = 0; m_we = 0; m_idx = 0; m_lo = 0;
    m_cmpd = 0; m_mask2 = 0; m_mwd = 0; m_page = 0; m_maddr = 0;
    for (int i = 0; i < 2; i++) begin
      m_ctrl[i] = 0; m_segc[i] = 0; m_addr[i] = 0; m_mask1[i] = 0; m_dst[i] = 0;
    end
  endtask

  task automatic m_tick();
    logic [7:0] op;
    logic [63:0] w;
    bit cw, dw, dr;
    op = dq_in[31:24];
    cw = acc_en && acc_wr && acc_cmd;
    dw = acc_en && acc_wr && !acc_cmd;
    dr = acc_en && !acc_wr && !acc_cmd;
    m_req = 0; m_we = 0;
    if (acc_en) begin
      m_pend = cw && op == 8'h10 && !dq_in[16];
      if (m_pend) m_idx = dq_in[18:17];
    end
    if (dr) m_seg = !m_seg;
    if (dw) begin
      if (!m_seg) begin
        m_lo = dq_in; m_seg = 1;
      end else begin
        w = {dq_in, m_lo}; m_seg = 0;
        case (m_dst[m_bank])
          2'd0: begin m_cmpd = w; m_req = 1; end
          2'd1: begin m_mask1[m_bank] = w; m_req = 1; end
          2'd2: begin m_mask2 = w; m_req = 1; end
          default: begin
            m_we = 1; m_maddr = m_addr[m_bank]; m_mwd = w;
            if (m_ctrl[m_bank][1:0] == 2'b01) m_addr[m_bank] = (m_addr[m_bank] + 1) % (1 << AW);
            if (m_ctrl[m_bank][1:0] == 2'b10) m_addr[m_bank] = (m_addr[m_bank] + (1 << AW) - 1) % (1 << AW);
          end
        endcase
      end
    end
    if (cw) begin
      if (op == 8'h10 && dq_in[16]) begin
        case (dq_in[18:17])
          2'd0: begin m_ctrl[m_bank] = dq_in[15:0]; m_req = 1; end
          2'd1: begin m_segc[m_bank] = dq_in[15:0]; m_seg = 0; end
          2'd2: m_addr[m_bank] = int'(dq_in[AW-1:0]);
          default: m_page = dq_in[15:0];
        endcase
      end
      if (op == 8'h20) m_dst[m_bank] = dq_in[17:16];
      if (op == 8'h30) begin m_bank = dq_in[16]; m_seg = 0; end
      if (op == 8'h40) m_req = 1;
      if (op == 8'h50) m_addr[m_bank] = int'(dq_in[AW-1:0]);
    end
  endtask

  task automatic step(bit en, bit wr, bit cmd, logic [31:0] d, string tag);
    acc_en = en; acc_wr = wr; acc_cmd = cmd; dq_in = d;
    #2;
    chk(tag, "dq_oe", 64'(dq_oe), 64'(en && !wr));
    chk(tag, "dq_out", 64'(dq_out), 64'(exp_dq()));
    @(posedge clk);
    m_tick();
    #1;
    chk(tag, "cmp_req", 64'(cmp_req), 64'(m_req));
    chk(tag, "mem_we", 64'(mem_we), 64'(m_we));
    if (m_we) begin
      chk(tag, "mem_addr", 64'(mem_addr), 64'(m_maddr));
      chk(tag, "mem_wdata", mem_wdata, m_mwd);
    end
    chk(tag, "cmp_key", cmp_key, m_cmpd);
    chk(tag, "cmp_mask", cmp_mask, exp_mask());
    @(negedge clk);
  endtask

  task automatic cw(logic [31:0] d, string tag); step(1, 1, 1, d, tag); endtask
  task automatic dw(logic [31:0] d, string tag); step(1, 1, 0, d, tag); endtask
  task automatic cr(string tag); step(1, 0, 1, 32'h0, tag); endtask
  task automatic dr(string tag); step(1, 0, 0, 32'h0, tag); endtask

  initial begin
    #1000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; acc_en = 0; acc_wr = 0; acc_cmd = 0; dq_in = 0;
    res_hit = 0; res_multi = 0; res_addr = 0;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R12", "reset cmp_req", 64'(cmp_req), 0);
    chk("R12", "reset mem_we", 64'(mem_we), 0);
    chk("R12", "reset cmp_key", cmp_key, 0);
    chk("R12", "reset cmp_mask", cmp_mask, {64{1'b1}});
    chk("R12", "reset dq_oe", 64'(dq_oe), 0);
    @(negedge clk);

    res_hit = 1; res_addr = 16'h1234;
    cr("R2");
    step(0, 0, 1, 32'hFFFF_FFFF, "R1");
    cw(32'h1001_0004, "R3");
    cw(32'h2000_0000, "R5");
    dw(32'h1111_2222, "R5");
    dw(32'hA5A5_0F0F, "R5");
    dr("R7");
    dr("R7");
    step(0, 1, 0, 32'h1234_5678, "R12");
    step(0, 1, 1, 32'h3001_0000, "R12");
    cw(32'h2001_0000, "R5");
    dw(32'hFFFF_0000, "R11");
    dw(32'h0000_FFFF, "R11");
    cw(32'h1000_0000, "R4");
    cr("R4");
    cw(32'h1007_00AB, "R3");
    cw(32'h1006_0000, "R4");
    cr("R4");
    cw(32'h1000_0000, "R4");
    dw(32'h0000_0001, "R4");
    cr("R4");
    dw(32'h0000_0000, "R7");
    dw(32'hDEAD_BEEF, "R7");
    cw(32'h1003_0055, "R7");
    dw(32'h0000_00FF, "R7");
    dw(32'h0000_0000, "R7");
    cw(32'h1002_0000, "R4");
    cr("R4");

    cw(32'h3001_0000, "R8");
    cr("R8");
    cw(32'h1001_0001, "R9");
    cw(32'h2003_0000, "R9");
    cw(32'h5000_000E, "R10");
    cw(32'h1004_0000, "R10");
    cr("R10");
    for (int k = 0; k < 3; k++) begin
      dw(32'h0000_0100 + k, "R9");
      dw(32'hC0DE_0000 + k, "R9");
    end
    cw(32'h1001_0002, "R9");
    for (int k = 0; k < 3; k++) begin
      dw(32'h0000_0200 + k, "R9");
      dw(32'hBEAD_0000 + k, "R9");
    end
    dr("R7");
    dr("R7");
    cw(32'h3000_0000, "R8");
    cw(32'h1004_0000, "R8");
    cr("R8");
    cw(32'h1001_0008, "R11");
    cw(32'h2002_0000, "R11");
    dw(32'h0F0F_0F0F, "R11");
    dw(32'hF0F0_F0F0, "R11");
    cw(32'h4000_0000, "R6");
    cw(32'h7700_0000, "R6");
    res_hit = 0; res_multi = 1; res_addr = 16'hBEEF;
    cr("R2");
    step(0, 0, 0, 32'h0, "R1");
    dw(32'h0000_0001, "R1");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule